// File: doc/BRIEF.md
# Toggle-Handshake Write Pulse Synchronizer

This block carries isolated write requests from a slow write-clock domain into a faster RAM-clock domain. Each enabled write loads the data word into a holding register. On the same write-clock edge it inverts a single toggle flag. Only the toggle crosses the clock boundary.

In the RAM domain, a four-state machine samples the toggle and steps through a Gray-coded loop. The machine advances through a sampling state only when the toggle value differs from that state's expectation. The two remaining states are unconditional pass-through states. The write strobe is the exclusive-OR of the two state bits, so each toggle change produces one strobe exactly one RAM cycle wide.

The data output is taken directly from the holding register. It is valid beside the strobe because the word is loaded on the same edge that flips the toggle. A parameter can add flip-flop stages on the toggle ahead of the state machine. Each added stage gives more settling margin for metastability and adds one RAM cycle of latency.

Top module: `wrPulseSync`

## Requirements
- R1: The toggle inverts only on write-clock edges where `wrEn` is high. While `wrEn` stays low, `ramWe` never asserts.
- R2: On every write-clock edge with `wrEn` high, `wrData` is loaded into the holding register on that same edge. `ramData` shows the most recently loaded word.
- R3: With `EXTRA_STAGES` = 0, `ramWe` is high during the RAM-clock cycle that begins at the first RAM-clock rising edge after the write edge. Each extra stage delays the strobe by exactly one more RAM-clock cycle.
- R4: `ramWe` is high for exactly one RAM-clock cycle per strobe.
- R5: The RAM-side state register takes the encodings 00, 01, 11 and 10. From 00 it moves to 01 when the sampled toggle is 1, and from 11 it moves to 10 when the sampled toggle is 0. State 01 always moves to 11, and state 10 always moves to 00. At most one state bit changes per cycle.
- R6: Writes may be spaced at least four RAM-clock cycles apart. Under that spacing, the number of `ramWe` strobes equals the number of accepted writes, with none lost and none duplicated.
- R7: While in reset, and after `wrRstN` and `ramRstN` are released, `ramWe` is 0 and `ramData` is 0. This holds even if a write had flipped the toggle just before reset. The block accepts writes normally afterwards.
- R8: `ramData` holds the strobed word unchanged from the strobe cycle until the next accepted write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-domain clock |
| wrRstN | input | 1 | Asynchronous active-low reset, write domain |
| wrEn | input | 1 | Write request, sampled on wrClk |
| wrData | input | DATA_W | Word to be written |
| ramClk | input | 1 | RAM-domain clock, faster than the write rate |
| ramRstN | input | 1 | Asynchronous active-low reset, RAM domain |
| ramWe | output | 1 | One-cycle write strobe in the RAM domain |
| ramData | output | DATA_W | Held word accompanying the strobe |

## Verification
The bench runs two instances side by side: one with no extra stage and one with a single extra stage. It checks the exact RAM cycle in which each instance strobes. A wrong stage count or an extra register would move the strobe by a cycle. A machine missing a pass-through state would emit a double-wide strobe or a second strobe from one toggle.

A back-to-back burst at the tightest spacing allowed exposes lost or duplicated strobes and data that is not yet loaded when the strobe fires. A reset applied while a flipped toggle is still in flight catches a domain that resets out of step with the other. That fault would produce a spurious strobe after reset is released.

// File: rtl/tps_pkg.sv
package tps_pkg;

  // RAM-side sequence; the encoding is Gray so that one bit moves per step
  typedef enum logic [1:0] {
    ST_REST0 = 2'b00,
    ST_SAW1  = 2'b01,
    ST_REST1 = 2'b11,
    ST_SAW0  = 2'b10
  } ramState_t;

  // write-domain strobes from the top into the write path
  typedef struct packed {
    logic load;
    logic flip;
  } wrCmd_t;

  // RAM-domain strobes out of the control
  typedef struct packed {
    logic we;
  } ramCmd_t;

endpackage

// File: rtl/tps_wr_path.sv
module tps_wr_path
  import tps_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  wrCmd_t            cmd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] holdData,
  output logic              toggle
);

  logic [DATA_W-1:0] holdReg;
  logic              togReg;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      holdReg <= '0;
    end else if (cmd.load) begin
      holdReg <= wrData;
    end
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      togReg <= 1'b0;
    end else if (cmd.flip) begin
      togReg <= ~togReg;
    end
  end

  assign holdData = holdReg;
  assign toggle   = togReg;

  // R2
  hold_with_flip_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (holdReg != $past(holdReg)) |-> (togReg != $past(togReg)));

endmodule

// File: rtl/tps_ram_ctrl.sv
module tps_ram_ctrl
  import tps_pkg::*;
#(
  parameter int EXTRA_STAGES = 0
) (
  input  logic    ramClk,
  input  logic    ramRstN,
  input  logic    togIn,
  output ramCmd_t cmd
);

  logic      togSampled;
  ramState_t state;
  ramState_t stateNext;

  generate
    if (EXTRA_STAGES > 0) begin : g_pre
      logic [EXTRA_STAGES-1:0] chain;
      always_ff @(posedge ramClk or negedge ramRstN) begin
        if (!ramRstN) begin
          chain <= '0;
        end else begin
          chain[0] <= togIn;
          for (int i = 1; i < EXTRA_STAGES; i++) begin
            chain[i] <= chain[i-1];
          end
        end
      end
      assign togSampled = chain[EXTRA_STAGES-1];
    end else begin : g_direct
      assign togSampled = togIn;
    end
  endgenerate

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_REST0: stateNext = togSampled ? ST_SAW1 : ST_REST0;
      ST_SAW1:  stateNext = ST_REST1;
      ST_REST1: stateNext = togSampled ? ST_REST1 : ST_SAW0;
      ST_SAW0:  stateNext = ST_REST0;
      default:  stateNext = ST_REST0;
    endcase
  end

  always_ff @(posedge ramClk or negedge ramRstN) begin
    if (!ramRstN) begin
      state <= ST_REST0;
    end else begin
      state <= stateNext;
    end
  end

  assign cmd.we = state[1] ^ state[0];

  // R5
  gray_step_chk: assert property (@(posedge ramClk) disable iff (!ramRstN)
    $countones(state ^ $past(state)) <= 1);

  // R5
  pass_rise_chk: assert property (@(posedge ramClk) disable iff (!ramRstN)
    (state == ST_SAW1) |=> (state == ST_REST1));

  // R5
  pass_fall_chk: assert property (@(posedge ramClk) disable iff (!ramRstN)
    (state == ST_SAW0) |=> (state == ST_REST0));

  // R4
  one_cycle_we_chk: assert property (@(posedge ramClk) disable iff (!ramRstN)
    cmd.we |=> !cmd.we);

endmodule

// File: rtl/wrPulseSync.sv
module wrPulseSync
  import tps_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int EXTRA_STAGES = 0
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ramClk,
  input  logic              ramRstN,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramData
);

  wrCmd_t  wrCmd;
  ramCmd_t ramCmd;
  logic    toggle;

  assign wrCmd.load = wrEn;
  assign wrCmd.flip = wrEn;

  tps_wr_path #(.DATA_W(DATA_W)) u_wr_path (
    .wrClk   (wrClk),
    .wrRstN  (wrRstN),
    .cmd     (wrCmd),
    .wrData  (wrData),
    .holdData(ramData),
    .toggle  (toggle)
  );

  tps_ram_ctrl #(.EXTRA_STAGES(EXTRA_STAGES)) u_ram_ctrl (
    .ramClk (ramClk),
    .ramRstN(ramRstN),
    .togIn  (toggle),
    .cmd    (ramCmd)
  );

  assign ramWe = ramCmd.we;

endmodule

// File: tb/wrPulseSync_tb.sv
module wrPulseSync_tb;

  localparam int DW = 8;

  logic          wrClk, ramClk, wrRstN, ramRstN, wrEn;
  logic [DW-1:0] wrData;
  logic          we0, we1;
  logic [DW-1:0] d0, d1;

  int nChecks = 0;
  int nFails  = 0;
  int cnt0 = 0, cnt1 = 0;
  logic prev0 = 1'b0, prev1 = 1'b0;
  logic [DW-1:0] expWord = '0;
  bit done = 0;

  wrPulseSync #(.DATA_W(DW), .EXTRA_STAGES(0)) u_dut (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData),
    .ramClk(ramClk), .ramRstN(ramRstN), .ramWe(we0), .ramData(d0));

  wrPulseSync #(.DATA_W(DW), .EXTRA_STAGES(1)) u_dut_x1 (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData),
    .ramClk(ramClk), .ramRstN(ramRstN), .ramWe(we1), .ramData(d1));

  // RAM clock 125 MHz; write clock 25 MHz, edges offset from RAM edges
  initial begin ramClk = 0; forever #4 ramClk = ~ramClk; end
  initial begin wrClk = 0; #2; forever #20 wrClk = ~wrClk; end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // strobe monitor, sampled on the falling RAM edge
  always @(negedge ramClk) begin
    if (wrRstN && ramRstN) begin
      if (we0) begin
        cnt0++;
        check(d0 == expWord, "R2 data at strobe (no extra stage)", d0, expWord);
        check(!prev0, "R4 strobe width (no extra stage)", 2, 1);
      end
      if (we1) begin
        cnt1++;
        check(d1 == expWord, "R2 data at strobe (extra stage)", d1, expWord);
        check(!prev1, "R4 strobe width (extra stage)", 2, 1);
      end
    end
    prev0 = we0;
    prev1 = we1;
  end

  task automatic doWrite(input logic [DW-1:0] w);
    @(negedge wrClk);
    wrEn = 1'b1; wrData = w; expWord = w;
    @(posedge wrClk);
    #1 wrEn = 1'b0;
  endtask

  task automatic testReset();
    // R7
    check(we0 == 0 && we1 == 0, "R7 strobe low in reset", we0 | we1, 0);
    check(d0 == 0 && d1 == 0, "R7 data zero in reset", d0 | d1, 0);
  endtask

  task automatic testIdle();
    int c0 = cnt0, c1 = cnt1;
    repeat (12) @(posedge wrClk);
    #1;
    // R1: no enable, no strobe
    check(cnt0 == c0 && cnt1 == c1, "R1 idle gives no strobe", cnt0 + cnt1 - c0 - c1, 0);
  endtask

  task automatic testLatency(input logic [DW-1:0] w);
    doWrite(w);
    @(posedge ramClk); #1;
    check(we0 == 1, "R3 strobe on first RAM edge", we0, 1);
    check(we1 == 0, "R3 extra stage not yet", we1, 0);
    check(d0 == w, "R2 word beside strobe", d0, w);
    @(posedge ramClk); #1;
    check(we0 == 0, "R4 strobe dropped", we0, 0);
    check(we1 == 1, "R3 extra stage one edge later", we1, 1);
    @(posedge ramClk); #1;
    check(we1 == 0, "R4 extra-stage strobe dropped", we1, 0);
    check(d0 == w && d1 == w, "R8 data held after strobe", d0, w);
    repeat (3) @(posedge ramClk); #1;
    check(d0 == w, "R8 data held until next write", d0, w);
  endtask

  task automatic testBurst(input int n, input logic [DW-1:0] seed);
    int c0 = cnt0, c1 = cnt1;
    @(negedge wrClk);
    for (int i = 0; i < n; i++) begin
      wrEn = 1'b1; wrData = seed + DW'(i * 37); expWord = wrData;
      @(negedge wrClk);
    end
    wrEn = 1'b0;
    repeat (4) @(posedge wrClk);
    #1;
    // R6 R5: one strobe per write at five RAM cycles per write
    check(cnt0 - c0 == n, "R6 strobe count (no extra stage)", cnt0 - c0, n);
    check(cnt1 - c1 == n, "R6 strobe count (extra stage)", cnt1 - c1, n);
  endtask

  task automatic testResetInFlight();
    int c0, c1;
    doWrite(8'hC3);
    wrRstN = 0; ramRstN = 0;
    #30;
    testReset();
    @(negedge ramClk); ramRstN = 1;
    @(negedge wrClk);  wrRstN = 1;
    c0 = cnt0; c1 = cnt1;
    repeat (6) @(posedge wrClk);
    #1;
    // R7
    check(cnt0 == c0 && cnt1 == c1, "R7 no strobe after reset", cnt0 + cnt1 - c0 - c1, 0);
    check(d0 == 0, "R7 data zero after reset", d0, 0);
  endtask

  initial begin
    wrRstN = 0; ramRstN = 0; wrEn = 0; wrData = '0;
    #50;
    testReset();
    @(negedge wrClk); wrRstN = 1; ramRstN = 1;
    testIdle();
    testLatency(8'hA5);
    testLatency(8'h5A);
    testBurst(8, 8'h11);
    testIdle();
    testResetInFlight();
    testLatency(8'h3C);
    testBurst(5, 8'hF0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule